// File: doc/BRIEF.md
# Real-time clock control core

This block keeps time of day for a chip that receives a 32.768 kHz enable. The enable drives a 15-stage binary prescaler. Each time the prescaler wraps, a one-cycle seconds strobe advances a chain of BCD counters for seconds, minutes and hours. Hours can be kept in 24-hour form or in 12-hour form with a PM flag.

A 4-bit control register sets the behaviour of the block:
- RESET holds the upper sub-second stages at zero.
- STOP freezes the chain so that it can serve as an accumulating timer.
- A mode bit selects 12-hour or 24-hour counting.
- TEST makes the seconds advance quickly.

A host writes the control register and the three time registers through a simple write port. The port is qualified by a chip-select input. Dropping chip-select also releases the RESET bit by itself.

Register addresses (on `wrAddr`):
- 0: control, data[3:0]
- 1: seconds, data[6:0] BCD
- 2: minutes, data[6:0] BCD
- 3: hours, data[5:0] BCD, with data[6] the PM flag

Control bits: bit 0 RESET, bit 1 STOP, bit 2 MODE24, bit 3 TEST.

Top module: `rtc_ctrl_core`

## Requirements
- R1: After `rstN` is deasserted, the time reads 00:00:00, `pmFlag` is 0, `secTick` is 0 and `ctrlBits` reads 4'b0100 (24-hour mode, all other bits 0).
- R2: While `chipSel` is 1, a write to address 0 loads data[3:0] into the control register, where bit 0 is RESET, bit 1 is STOP, bit 2 is MODE24 and bit 3 is TEST. The new value shows on `ctrlBits` after the next clock edge.
- R3: With all control bits except MODE24 clear, the seconds advance once every 32768 `tickEn` cycles. A write to the seconds register clears the whole prescaler, so the next advance comes exactly 32768 enabled cycles after the write edge. Each advance raises `secTick` for exactly one cycle, together with the new value.
- R4: Seconds and minutes are two-digit BCD values. Each rolls over from 59 to 00 and carries into the next register.
- R5: With MODE24 = 1, hours run from 00 to 23 and then roll to 00. In this mode `pmFlag` reads 0 whatever PM value is stored.
- R6: With MODE24 = 0, hours run 12, 01, 02, … 11. `pmFlag` toggles on the step from 11:59:59 to 12:00:00, and reads 1 for p.m.
- R7: While STOP = 1, no seconds advance occurs and all time values hold. Clearing STOP resumes counting from the held value.
- R8: While RESET = 1, the prescaler stages from the 1/256 s stage upward stay at zero, so no seconds advance occurs in normal mode. After RESET is cleared, the next advance comes within 32768 enabled cycles.
- R9: When `chipSel` is 0, RESET is cleared at the next edge, and writes to any register are ignored.
- R10: With TEST = 1 (and STOP = 0), the seconds advance once every 4 enabled cycles.
- R11: Changing MODE24 does not convert the stored hour or PM value. Both read back unchanged.
- R12: A write to a time register wins over an increment of that register in the same cycle. A seconds write in a cycle where a carry was due produces neither a `secTick` nor a carry into the minutes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle 32.768 kHz count enable |
| chipSel | input | 1 | Host select; its low level clears RESET and blocks writes |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 control, 1 seconds, 2 minutes, 3 hours |
| wrData | input | 7 | Write data |
| secBcd | output | 8 | Seconds, BCD |
| minBcd | output | 8 | Minutes, BCD |
| hourBcd | output | 8 | Hours, BCD |
| pmFlag | output | 1 | PM indicator, forced to 0 in 24-hour mode |
| ctrlBits | output | 4 | Current control register |
| secTick | output | 1 | One-cycle pulse on every seconds advance |

## Verification
A corrupted prescaler shows up only as a seconds strobe that arrives at the wrong moment. The bench therefore times the gap from a seconds write to the first strobe to the exact cycle, and measures the 4-cycle period in test mode.

A wrong carry or hour-sequence state appears on the strobe at which it occurs. A scoreboard compares the full time and PM word on every strobe against values pushed in advance. An extra or a missing advance shows up as an unexpected strobe or an undrained queue.

Flags that hold or block counting (STOP, RESET, chip-select) are judged by the absence of strobes over long windows, followed by an exact resume value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Strobes passed from control to the time datapath
  typedef struct packed {
    logic       secInc;
    logic       wrSec;
    logic       wrMin;
    logic       wrHour;
    logic       mode24;
    logic [6:0] wrValue;
  } tStrobe_t;

  // Add one to a two-digit BCD value (no modulus applied)
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int PRESC_W  = 15,
  parameter int STOP_LSB = 2,
  parameter int RST_LSB  = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       chipSel,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [6:0] wrData,
  output logic [3:0] ctrlBits,
  output tStrobe_t   strobe
);
  localparam int HIGH_W = PRESC_W - STOP_LSB;
  localparam int KEEP_W = RST_LSB - STOP_LSB;
  localparam logic [HIGH_W-1:0] KEEP_MASK = HIGH_W'((1 << KEEP_W) - 1);

  logic [3:0]          ctrlQ;
  logic [STOP_LSB-1:0] lowQ;
  logic [HIGH_W-1:0]   highQ, highNext;
  logic wrAct, lowWrap, fullWrap, resetBit, stopBit, testBit, wrSec;

  assign resetBit = ctrlQ[0];
  assign stopBit  = ctrlQ[1];
  assign testBit  = ctrlQ[3];
  assign wrAct    = wrEn & chipSel;
  assign wrSec    = wrAct && (wrAddr == 2'd1);

  // Control register; a low chip-select releases the hold bit
  always_ff @(posedge clk) begin
    if (!rstN)                        ctrlQ <= 4'b0100;
    else if (!chipSel)                ctrlQ[0] <= 1'b0;
    else if (wrEn && wrAddr == 2'd0)  ctrlQ <= wrData[3:0];
  end

  // Prescaler: low stages free-running, upper stages gated by STOP
  assign lowWrap  = tickEn & (&lowQ);
  assign fullWrap = lowWrap & (&highQ);

  always_comb begin
    highNext = highQ;
    if (lowWrap && !stopBit) highNext = highQ + 1'b1;
    if (resetBit)            highNext = highNext & KEEP_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN || wrSec) begin
      lowQ  <= '0;
      highQ <= '0;
    end else begin
      if (tickEn) lowQ <= lowQ + 1'b1;
      highQ <= highNext;
    end
  end

  always_comb begin
    strobe.secInc  = !stopBit && (testBit ? lowWrap : fullWrap);
    strobe.wrSec   = wrSec;
    strobe.wrMin   = wrAct && (wrAddr == 2'd2);
    strobe.wrHour  = wrAct && (wrAddr == 2'd3);
    strobe.mode24  = ctrlQ[2];
    strobe.wrValue = wrData;
  end

  assign ctrlBits = ctrlQ;
endmodule

// File: rtl/rtc_time.sv
module rtc_time
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tStrobe_t   strobe,
  output logic [7:0] secBcd,
  output logic [7:0] minBcd,
  output logic [7:0] hourBcd,
  output logic       pmRaw,
  output logic       secTick
);
  logic [7:0] secQ, minQ, hourQ, hourNext;
  logic       pmQ, pmNext, secWrap, minWrap, minInc, hourInc;

  assign secWrap = (secQ == 8'h59);
  assign minWrap = (minQ == 8'h59);
  assign minInc  = strobe.secInc & secWrap & ~strobe.wrSec;
  assign hourInc = minInc & minWrap & ~strobe.wrMin;

  always_comb begin
    hourNext = bcdInc(hourQ);
    pmNext   = pmQ;
    if (strobe.mode24) begin
      if (hourQ == 8'h23) hourNext = 8'h00;
    end else if (hourQ == 8'h12) begin
      hourNext = 8'h01;
    end else if (hourQ == 8'h11) begin
      pmNext = ~pmQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= '0; minQ <= '0; hourQ <= '0; pmQ <= 1'b0; secTick <= 1'b0;
    end else begin
      secTick <= strobe.secInc & ~strobe.wrSec;
      if (strobe.wrSec)       secQ <= {1'b0, strobe.wrValue};
      else if (strobe.secInc) secQ <= secWrap ? 8'h00 : bcdInc(secQ);
      if (strobe.wrMin)       minQ <= {1'b0, strobe.wrValue};
      else if (minInc)        minQ <= minWrap ? 8'h00 : bcdInc(minQ);
      if (strobe.wrHour) begin
        hourQ <= {2'b00, strobe.wrValue[5:0]};
        pmQ   <= strobe.wrValue[6];
      end else if (hourInc) begin
        hourQ <= hourNext;
        pmQ   <= pmNext;
      end
    end
  end

  assign secBcd  = secQ;
  assign minBcd  = minQ;
  assign hourBcd = hourQ;
  assign pmRaw   = pmQ;
endmodule

// File: rtl/rtc_ctrl_core.sv
module rtc_ctrl_core
  import rtc_pkg::*;
#(
  parameter int PRESC_W  = 15,
  parameter int STOP_LSB = 2,
  parameter int RST_LSB  = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       chipSel,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [6:0] wrData,
  output logic [7:0] secBcd,
  output logic [7:0] minBcd,
  output logic [7:0] hourBcd,
  output logic       pmFlag,
  output logic [3:0] ctrlBits,
  output logic       secTick
);
  tStrobe_t strobe;
  logic     pmRaw;

  rtc_ctrl #(.PRESC_W(PRESC_W), .STOP_LSB(STOP_LSB), .RST_LSB(RST_LSB)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .chipSel(chipSel), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .ctrlBits(ctrlBits), .strobe(strobe)
  );

  rtc_time u_time (
    .clk(clk), .rstN(rstN), .strobe(strobe), .secBcd(secBcd), .minBcd(minBcd),
    .hourBcd(hourBcd), .pmRaw(pmRaw), .secTick(secTick)
  );

  assign pmFlag = pmRaw & ~ctrlBits[2];
endmodule

// File: rtl/rtc_ctrl_core_chk.sv
module rtc_ctrl_core_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       chipSel,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic [6:0] wrData,
  input logic [7:0] secBcd,
  input logic [7:0] minBcd,
  input logic [7:0] hourBcd,
  input logic       pmFlag,
  input logic [3:0] ctrlBits,
  input logic       secTick
);
  p_tick_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick);

  p_sec_roll_r4: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && $past(secBcd) == 8'h59) |-> (secBcd == 8'h00));

  p_day_roll_r5: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && $past(ctrlBits[2]) && $past(hourBcd) == 8'h23 &&
     $past({minBcd, secBcd}) == 16'h5959) |-> (hourBcd == 8'h00));

  p_noon_flip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !$past(ctrlBits[2]) && $past(hourBcd) == 8'h11 &&
     $past({minBcd, secBcd}) == 16'h5959) |-> (hourBcd == 8'h12 && pmFlag != $past(pmFlag)));

  p_stop_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlBits[1]) |-> !secTick);

  p_reset_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlBits[0], 2) && !$past(ctrlBits[3])) |-> !secTick);

  p_cs_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> !ctrlBits[0]);
endmodule

bind rtc_ctrl_core rtc_ctrl_core_chk u_chk (.*);

// File: tb/rtc_ctrl_core_bench.sv
module rtc_ctrl_core_bench;
  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, chipSel = 1'b1, wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [6:0] wrData = '0;
  logic [7:0] secBcd, minBcd, hourBcd;
  logic       pmFlag, secTick;
  logic [3:0] ctrlBits;

  int checks = 0, errors = 0;
  logic [24:0] expQ[$];
  string       tagQ[$];
  string       curTag = "R7";

  always #2 clk = ~clk;

  rtc_ctrl_core u_rtc_ctrl_core (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .chipSel(chipSel), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .secBcd(secBcd), .minBcd(minBcd),
    .hourBcd(hourBcd), .pmFlag(pmFlag), .ctrlBits(ctrlBits), .secTick(secTick)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: every seconds strobe must match the next queued item
  always @(negedge clk) begin
    if (rstN && secTick) begin
      if (expQ.size() == 0) check(1'b0, {curTag, " unexpected tick"}, {pmFlag, hourBcd, minBcd, secBcd}, 0);
      else begin
        logic [24:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({pmFlag, hourBcd, minBcd, secBcd} == e, t, {pmFlag, hourBcd, minBcd, secBcd}, e);
      end
    end
  end

  task automatic pushExp(input string tag, input bit pm, input logic [7:0] h, m, s);
    expQ.push_back({pm, h, m, s});
    tagQ.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setTime(input logic [5:0] h, input bit pm, input logic [6:0] m, s);
    wr(2'd3, {pm, h});
    wr(2'd2, m);
    wr(2'd1, s);
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (expQ.size() != 0 && n < 2000) begin
      @(negedge clk); #1; n++;
    end
    check(expQ.size() == 0, {tag, " queue drained"}, expQ.size(), 0);
    tickEn = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({hourBcd, minBcd, secBcd} == 0, "R1 time", {hourBcd, minBcd, secBcd}, 0);
    check(ctrlBits == 4'b0100 && !pmFlag && !secTick, "R1 ctrl/pm/tick", {pmFlag, secTick, ctrlBits}, 4'b0100);

    // R3: exact period after a seconds write
    curTag = "R3";
    tickEn = 1'b1;
    wr(2'd1, 7'h30);
    pushExp("R3 first advance", 0, 8'h00, 8'h00, 8'h31);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!secTick && n < 40000);
    check(n == 32768, "R3 cycles to advance", n, 32768);
    tickEn = 1'b0;
    @(negedge clk); #1;

    // R2: control write visible
    wr(2'd0, 7'h0E);
    check(ctrlBits == 4'hE, "R2 ctrl write", ctrlBits, 4'hE);

    // R4/R5: day rollover in 24-hour fast mode
    curTag = "R5";
    setTime(6'h23, 0, 7'h59, 7'h58);
    wr(2'd0, 7'h0C);
    pushExp("R4 sec", 0, 8'h23, 8'h59, 8'h59);
    pushExp("R5 rollover", 0, 8'h00, 8'h00, 8'h00);
    tickEn = 1'b1;
    drain("R5");

    // R10: 4-cycle period in test mode
    curTag = "R10";
    setTime(6'h00, 0, 7'h00, 7'h00);
    pushExp("R10 a", 0, 8'h00, 8'h00, 8'h01);
    pushExp("R10 b", 0, 8'h00, 8'h00, 8'h02);
    tickEn = 1'b1;
    n = 0;
    do begin @(posedge clk); #1; end while (!secTick);
    do begin @(posedge clk); #1; n++; end while (!secTick && n < 20);
    check(n == 4, "R10 period", n, 4);
    drain("R10");

    // R6: 12-hour sequence
    curTag = "R6";
    wr(2'd0, 7'h08);
    setTime(6'h11, 0, 7'h59, 7'h58);
    pushExp("R6 am", 0, 8'h11, 8'h59, 8'h59);
    pushExp("R6 noon", 1, 8'h12, 8'h00, 8'h00);
    pushExp("R6 after noon", 1, 8'h12, 8'h00, 8'h01);
    tickEn = 1'b1;
    drain("R6");
    setTime(6'h12, 1, 7'h59, 7'h59);
    pushExp("R6 one pm", 1, 8'h01, 8'h00, 8'h00);
    tickEn = 1'b1;
    drain("R6");
    setTime(6'h11, 1, 7'h59, 7'h59);
    pushExp("R6 midnight", 0, 8'h12, 8'h00, 8'h00);
    tickEn = 1'b1;
    drain("R6");

    // R7: stop holds, then resumes
    curTag = "R7";
    setTime(6'h05, 0, 7'h10, 7'h20);
    wr(2'd0, 7'h0E);
    tickEn = 1'b1;
    repeat (100) @(negedge clk);
    check(secBcd == 8'h20 && minBcd == 8'h10, "R7 held", {minBcd, secBcd}, 16'h1020);
    pushExp("R7 resume", 0, 8'h05, 8'h10, 8'h21);
    wr(2'd0, 7'h0C);
    drain("R7");

    // R5/R11: pm hidden in 24h, stored value kept over mode change
    curTag = "R11";
    wr(2'd0, 7'h0E);
    setTime(6'h15, 1, 7'h00, 7'h00);
    check(pmFlag == 1'b0, "R5 pm forced 0", pmFlag, 0);
    wr(2'd0, 7'h0A);
    check(hourBcd == 8'h15 && pmFlag, "R11 no conversion", {pmFlag, hourBcd}, 9'h115);

    // R12: seconds write coincident with a due carry
    curTag = "R12";
    wr(2'd0, 7'h0C);
    setTime(6'h01, 0, 7'h10, 7'h59);
    tickEn = 1'b1;
    repeat (3) @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd1; wrData = 7'h20;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
    #1;
    check(secBcd == 8'h20 && minBcd == 8'h10 && !secTick, "R12 write wins",
          {secTick, minBcd, secBcd}, 17'h01020);

    // R8/R9: hold bit, then chip-select release
    curTag = "R8";
    wr(2'd0, 7'h04);
    setTime(6'h00, 0, 7'h00, 7'h05);
    wr(2'd0, 7'h05);
    check(ctrlBits == 4'h5, "R2 reset bit set", ctrlBits, 4'h5);
    tickEn = 1'b1;
    repeat (33000) @(negedge clk);
    check(secBcd == 8'h05, "R8 no advance while held", secBcd, 8'h05);
    chipSel = 1'b0;
    @(negedge clk);
    check(ctrlBits == 4'h4, "R9 reset bit cleared", ctrlBits, 4'h4);
    wr(2'd1, 7'h45);
    check(secBcd == 8'h05, "R9 write ignored", secBcd, 8'h05);
    pushExp("R8 resume", 0, 8'h00, 8'h00, 8'h06);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!secTick && n < 40000);
    check(n > 32768 - 140 && n <= 32768, "R8 resume window", n, 32768);
    tickEn = 1'b0;
    chipSel = 1'b1;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8 queue drained", expQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule